// File: doc/BRIEF.md
# Audio Serial-Port Clock Generator with Phase-Loss Reset

This block produces the bit clock and word clock of an audio serial port from the master clock, or accepts them from outside. The master clock is the block's own clock, `clk`. When `master_en` is high, a free-running even divider produces both clocks. `pins_oe` then tells the pad ring to drive them and to forward the master clock on its own pad. When `master_en` is low, the two clocks come in from the pins. They pass through a synchronizer, and the core-facing outputs carry them on. A select pin picks a master clock of 256 or 512 times the sample rate. A second pin picks 64 or 32 bit clocks per frame.

The block also watches the phase of the word clock. Every word-clock rising edge is measured against the previous one in master-clock cycles. If the frame length differs from its nominal value by more than a tolerance of ten cycles, a one-cycle `phase_rst` pulse tells the codec to resynchronize. After a pulse, the next edge only re-establishes the reference. The same holds for the first edge after reset or after a change of master/slave mode.

The block has no data path, so every pin is a plain level signal.

Top module: `audio_clkgen`

## Requirements
- R1: In master mode the word clock period is 256 master-clock cycles when `mclk_x2` is 0 and 512 when it is 1.
- R2: In master mode the word clock has a 50% duty cycle: it stays high for exactly half of each period.
- R3: In master mode one word-clock period contains 64 bit-clock rising edges when `short_frame` is 0 and 32 when it is 1. The bit clock is high for half of all cycles.
- R4: `pins_oe` is 1 in master mode and 0 in slave mode. In slave mode `bclk_o` and `wclk_o` stay 0 from the second slave cycle on.
- R5: In slave mode `core_bclk`/`core_wclk` equal `bclk_in`/`wclk_in` delayed by SYNC_STAGES (default 2) cycles. In master mode they equal `bclk_o`/`wclk_o`.
- R6: While checking is armed, an interval between word-clock rising edges that differs from the nominal frame length by more than PHASE_TOL (default 10) cycles raises `phase_rst`. A difference of PHASE_TOL or less raises nothing.
- R7: `phase_rst` is high for exactly one master-clock cycle per detected phase jump.
- R8: After a `phase_rst` pulse, after reset and after any change of `master_en`, the next word-clock rising edge only realigns the reference and never raises `phase_rst`. The edge after that is checked again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (256 or 512 times the sample rate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | 1: generate and drive clocks; 0: receive them |
| mclk_x2 | input | 1 | 0: master clock is 256 fs; 1: 512 fs |
| short_frame | input | 1 | 0: 64 bit clocks per frame; 1: 32 |
| bclk_in | input | 1 | Bit clock from the pin (slave mode) |
| wclk_in | input | 1 | Word clock from the pin (slave mode) |
| pins_oe | output | 1 | Drive enable for bit clock, word clock and forwarded master clock pads |
| bclk_o | output | 1 | Generated bit clock |
| wclk_o | output | 1 | Generated word clock |
| core_bclk | output | 1 | Bit clock used by the core (generated or synchronized input) |
| core_wclk | output | 1 | Word clock used by the core (generated or synchronized input) |
| phase_rst | output | 1 | One-cycle resynchronizing reset request |

## Verification
The hardest case to reach is the realignment rule. It needs a phase jump that fires the pulse and, right after it, a second out-of-tolerance interval that must stay silent. The jumps also have to sit exactly at the tolerance boundary (10 versus 11 cycles, early and late). A word clock running from the master divider never jumps, so the bench switches to slave mode and synthesizes the word clock frame by frame, stretching or shortening the low phase by a chosen number of cycles. It also changes the frame-length select in the middle of the stream. A bench model of the armed state predicts the pulse count for every stretch of frames, including a run of random jitter around the boundary.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  typedef struct packed {
    logic master;
    logic x2;
    logic short_frame;
  } aclk_cfg_t;

  function automatic int frame_cycles(input int base, input logic x2);
    return x2 ? 2 * base : base;
  endfunction
endpackage

// File: rtl/aclk_sync.sv
module aclk_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) stg[i] <= stg[i-1];
      stg[0] <= d;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/aclk_divider.sv
module aclk_divider #(
  parameter int BASE_RATIO = 256,
  parameter int FRAME_BITS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic x2,
  input  logic short_frame,
  output logic bclk,
  output logic wclk
);
  localparam int LB  = $clog2(BASE_RATIO);
  localparam int LF  = $clog2(FRAME_BITS);
  localparam int CW  = LB + 1;
  localparam int IXW = $clog2(CW);

  logic [CW-1:0]  cnt;
  logic [CW-1:0]  last;
  logic [IXW-1:0] w_ix;
  logic [IXW-1:0] b_ix;
  int             frame_lg;
  int             bits_lg;

  always_comb begin
    frame_lg = x2 ? LB + 1 : LB;
    bits_lg  = short_frame ? LF - 1 : LF;
    last     = x2 ? CW'(2 * BASE_RATIO - 1) : CW'(BASE_RATIO - 1);
    w_ix     = IXW'(frame_lg - 1);
    b_ix     = IXW'(frame_lg - bits_lg - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt >= last) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign bclk = cnt[b_ix];
  assign wclk = cnt[w_ix];
endmodule

// File: rtl/aclk_phase_mon.sv
module aclk_phase_mon #(
  parameter int BASE_RATIO = 256,
  parameter int PHASE_TOL  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon,
  input  logic x2,
  input  logic src_sel,
  output logic pulse
);
  localparam int IW = $clog2(4 * BASE_RATIO) + 1;

  logic [IW-1:0] ivl;
  logic [IW-1:0] nom;
  logic [IW-1:0] dev;
  logic          prev;
  logic          armed;
  logic          src_q;
  logic          rise;
  logic          src_chg;
  logic          late;

  always_comb begin
    nom     = x2 ? IW'(2 * BASE_RATIO) : IW'(BASE_RATIO);
    dev     = (ivl >= nom) ? ivl - nom : nom - ivl;
    late    = dev > IW'(PHASE_TOL);
    rise    = mon & ~prev;
    src_chg = src_sel ^ src_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl   <= '0;
      prev  <= 1'b0;
      armed <= 1'b0;
      src_q <= 1'b0;
      pulse <= 1'b0;
    end else begin
      prev  <= mon;
      src_q <= src_sel;
      pulse <= 1'b0;
      ivl   <= (&ivl) ? ivl : ivl + 1'b1;
      if (rise) begin
        ivl <= IW'(1);
        if (armed && late) begin
          pulse <= 1'b1;
          armed <= 1'b0;
        end else begin
          armed <= 1'b1;
        end
      end
      if (src_chg) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import aclk_pkg::*;
#(
  parameter int BASE_RATIO  = 256,
  parameter int FRAME_BITS  = 64,
  parameter int PHASE_TOL   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_en,
  input  logic mclk_x2,
  input  logic short_frame,
  input  logic bclk_in,
  input  logic wclk_in,
  output logic pins_oe,
  output logic bclk_o,
  output logic wclk_o,
  output logic core_bclk,
  output logic core_wclk,
  output logic phase_rst
);
  aclk_cfg_t cfg;
  logic      gen_b;
  logic      gen_w;
  logic      rx_b;
  logic      rx_w;
  logic      mon_w;

  assign cfg = '{master: master_en, x2: mclk_x2, short_frame: short_frame};

  aclk_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({bclk_in, wclk_in}),
    .q    ({rx_b, rx_w})
  );

  aclk_divider #(.BASE_RATIO(BASE_RATIO), .FRAME_BITS(FRAME_BITS)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (cfg.master),
    .x2         (cfg.x2),
    .short_frame(cfg.short_frame),
    .bclk       (gen_b),
    .wclk       (gen_w)
  );

  assign mon_w = cfg.master ? gen_w : rx_w;

  aclk_phase_mon #(.BASE_RATIO(BASE_RATIO), .PHASE_TOL(PHASE_TOL)) u_mon (
    .clk    (clk),
    .rst_n  (rst_n),
    .mon    (mon_w),
    .x2     (cfg.x2),
    .src_sel(cfg.master),
    .pulse  (phase_rst)
  );

  assign pins_oe   = cfg.master;
  assign bclk_o    = gen_b;
  assign wclk_o    = gen_w;
  assign core_bclk = cfg.master ? gen_b : rx_b;
  assign core_wclk = mon_w;
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk #(
  parameter int BASE_RATIO  = 256,
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic master_en,
  input logic mclk_x2,
  input logic short_frame,
  input logic bclk_in,
  input logic wclk_in,
  input logic pins_oe,
  input logic bclk_o,
  input logic wclk_o,
  input logic core_bclk,
  input logic core_wclk,
  input logic phase_rst
);
  localparam int LIMIT = 8 * BASE_RATIO + 8;
  localparam int SW    = $clog2(LIMIT + 1);
  localparam int RW    = $clog2(4 * BASE_RATIO);

  logic [1:0]    since_rst;
  logic [SW-1:0] steady;
  logic [2:0]    cfg_q;
  logic [RW-1:0] run_len;
  logic          prev_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      steady    <= '0;
      cfg_q     <= '0;
      run_len   <= '0;
      prev_w    <= 1'b0;
    end else begin
      since_rst <= (&since_rst) ? since_rst : since_rst + 1'b1;
      cfg_q     <= {master_en, mclk_x2, short_frame};
      prev_w    <= wclk_o;
      if (!master_en || cfg_q != {master_en, mclk_x2, short_frame}) steady <= '0;
      else if (steady < SW'(LIMIT)) steady <= steady + 1'b1;
      if (wclk_o != prev_w) run_len <= RW'(1);
      else if (!(&run_len)) run_len <= run_len + 1'b1;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rst |=> !phase_rst); // R7

  AST_SLAVE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && !master_en && $past(!master_en)) |-> (!pins_oe && !bclk_o && !wclk_o)); // R4

  AST_MASTER_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (steady >= SW'(LIMIT)) |-> !phase_rst); // R6

  AST_WCLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (steady >= SW'(LIMIT) && wclk_o != prev_w) |->
      (run_len == (mclk_x2 ? RW'(BASE_RATIO) : RW'(BASE_RATIO / 2)))); // R2

  generate
    if (SYNC_STAGES == 2) begin : g_follow
      AST_CORE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && !master_en) |->
          (core_wclk == $past(wclk_in, 2) && core_bclk == $past(bclk_in, 2))); // R5
    end else begin : g_follow_gen
      AST_CORE_GEN: assert property (@(posedge clk) disable iff (!rst_n)
        master_en |-> (core_wclk == wclk_o && core_bclk == bclk_o)); // R5
    end
  endgenerate
endmodule

bind audio_clkgen audio_clkgen_chk #(.BASE_RATIO(BASE_RATIO), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/sim_audio_clkgen.sv
module sim_audio_clkgen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 1'b1, mclk_x2 = 1'b0, short_frame = 1'b0;
  logic bclk_in = 1'b0, wclk_in = 1'b0;
  logic pins_oe, bclk_o, wclk_o, core_bclk, core_wclk, phase_rst;

  int nchk = 0, nfail = 0;
  int pcnt = 0, wide = 0;
  logic pprev = 1'b0;
  logic h1w = 0, h2w = 0, h1b = 0, h2b = 0;
  int hok = 0, seg_err = 0;
  int exp_p = 0, last_hi = 0, cur_n = 256;
  bit armed = 0;

  always #10 clk = ~clk;

  audio_clkgen u0 (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .mclk_x2(mclk_x2),
    .short_frame(short_frame), .bclk_in(bclk_in), .wclk_in(wclk_in),
    .pins_oe(pins_oe), .bclk_o(bclk_o), .wclk_o(wclk_o),
    .core_bclk(core_bclk), .core_wclk(core_wclk), .phase_rst(phase_rst)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (phase_rst) pcnt++;
      if (phase_rst && pprev) wide++;
      pprev = phase_rst;
    end
  end

  function automatic int frame_len(input logic x2);
    return x2 ? 512 : 256;
  endfunction

  function automatic int bits_per_frame(input logic sh);
    return sh ? 32 : 64;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  // master mode: measure one word-clock period starting at a rising edge
  task automatic measure(output int per, output int hi, output int be, output int bh, output int core_err);
    logic pw, pb;
    pw = wclk_o;
    forever begin
      @(negedge clk);
      if (wclk_o && !pw) break;
      pw = wclk_o;
    end
    per = 0; hi = 1; be = 0; bh = int'(bclk_o); pb = bclk_o; pw = 1'b1; core_err = 0;
    forever begin
      @(negedge clk);
      per++;
      if (core_wclk != wclk_o || core_bclk != bclk_o) core_err++;
      if (wclk_o && !pw) break;
      hi += int'(wclk_o);
      bh += int'(bclk_o);
      if (bclk_o && !pb) be++;
      pb = bclk_o;
      pw = wclk_o;
    end
  endtask

  task automatic step(input logic v);
    @(negedge clk);
    if (hok >= 2 && (core_wclk != h2w || core_bclk != h2b)) seg_err++;
    h2w = h1w; h2b = h1b;
    wclk_in = v;
    bclk_in = 1'($urandom);
    h1w = wclk_in; h1b = bclk_in;
    hok++;
  endtask

  // slave mode: one frame, low phase then high phase; models the armed state
  task automatic frame(input int lo, input int hi);
    int d;
    for (int i = 0; i < lo; i++) step(1'b0);
    d = last_hi + lo - cur_n;
    if (d < 0) d = -d;
    if (armed && d > 10) begin
      exp_p++;
      armed = 0;
    end else begin
      armed = 1;
    end
    for (int i = 0; i < hi; i++) step(1'b1);
    last_hi = hi;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R0 watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int per, hi, be, bh, cerr, p0, e0, w0;
    void'($urandom(32'h5EED_0A1C));
    repeat (3) @(negedge clk);
    // reset state
    chk("R7", "phase_rst in reset", int'(phase_rst), 0);
    chk("R1", "wclk_o in reset", int'(wclk_o), 0);
    chk("R3", "bclk_o in reset", int'(bclk_o), 0);
    rst_n = 1'b1;

    // master mode: all four rate/frame combinations, then random picks
    for (int k = 0; k < 6; k++) begin
      if (k < 4) begin
        mclk_x2 = 1'(k >> 1); short_frame = 1'(k);
      end else begin
        mclk_x2 = 1'($urandom); short_frame = 1'($urandom);
      end
      repeat (1100) @(negedge clk);
      p0 = pcnt;
      measure(per, hi, be, bh, cerr);
      chk("R1", "wclk period", per, frame_len(mclk_x2));
      chk("R2", "wclk high cycles", hi, frame_len(mclk_x2) / 2);
      chk("R3", "bclk rising per frame", be, bits_per_frame(short_frame));
      chk("R3", "bclk high cycles", bh, frame_len(mclk_x2) / 2);
      chk("R4", "pins_oe master", int'(pins_oe), 1);
      chk("R5", "core follows generated", cerr, 0);
      chk("R6", "no pulse on steady master", pcnt - p0, 0);
    end

    // enter slave mode with word clock input held low
    mclk_x2 = 1'b0; short_frame = 1'b0; cur_n = 256;
    wclk_in = 1'b0;
    repeat (5) @(negedge clk);
    master_en = 1'b0;
    armed = 0; hok = 0; last_hi = 0;
    repeat (3) @(negedge clk);
    chk("R4", "pins_oe slave", int'(pins_oe), 0);
    chk("R4", "bclk_o/wclk_o slave", int'(bclk_o) + int'(wclk_o), 0);

    p0 = pcnt; w0 = wide;
    for (int i = 0; i < 4; i++) frame(128, 128);
    chk("R8", "first edge after mode change realigns", pcnt - p0, 0);

    p0 = pcnt;
    frame(138, 128); frame(128, 128);
    chk("R6", "jump of +10 tolerated", pcnt - p0, 0);
    p0 = pcnt;
    frame(118, 128); frame(128, 128);
    chk("R6", "jump of -10 tolerated", pcnt - p0, 0);

    p0 = pcnt;
    frame(139, 128); frame(128, 128);
    chk("R6", "jump of +11 detected", pcnt - p0, 1);
    p0 = pcnt;
    frame(117, 128); frame(128, 128);
    chk("R6", "jump of -11 detected", pcnt - p0, 1);

    p0 = pcnt;
    frame(158, 128); frame(153, 128); frame(128, 128); frame(128, 128);
    chk("R8", "edge after pulse only realigns", pcnt - p0, 1);
    p0 = pcnt;
    frame(150, 128);
    chk("R8", "checking resumes after realign", pcnt - p0, 1);
    frame(128, 128);

    // random jitter around the boundary
    p0 = pcnt; e0 = exp_p;
    for (int i = 0; i < 30; i++) begin
      int j;
      j = int'($urandom_range(40)) - 20;
      frame(128 + j, 128);
    end
    chk("R6", "random jitter pulse count", pcnt - p0, exp_p - e0);

    // switch to 512 fs mid-stream
    p0 = pcnt; e0 = exp_p;
    mclk_x2 = 1'b1; cur_n = 512;
    for (int i = 0; i < 4; i++) frame(256, 256);
    frame(267, 256); frame(256, 256);
    frame(245, 256); frame(256, 256);
    chk("R1", "512 fs nominal frame and jump count", pcnt - p0, exp_p - e0);

    chk("R7", "pulses one cycle wide", wide - w0, 0);
    chk("R5", "core follows inputs by two cycles", seg_err, 0);

    summary();
    $finish;
  end
endmodule